// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

A 16-bit up-counter that advances once per count tick. The tick comes from a power-of-two prescaler on the system clock or from qualified edges on an external clock pin. Two channels share the counter, and each holds a 16-bit value register. In capture mode a channel copies the counter into that register when a qualified edge arrives on its trigger pin. In compare mode it signals when the counter equals the register. Channel 0 in compare mode sets the counter period. Channel 1 in compare mode toggles a registered timer output pin.

Software drives the block through a register port with no back-pressure. A write takes effect at the clock edge on which `bus_wr` is sampled. Read data appears on `bus_rdata` one cycle after `bus_rd` is sampled and is held until the next read. A single run bit both starts counting and acts as the reset of the counting logic. The clock selection, the mode/output register and the edge-select register are frozen while the run bit is set. Every pin input passes through a filter that accepts a new level only after the level has stayed stable.

Register map: address 0 is CTRL, with bit 0 = run and bits 3:1 = clock select. Address 1 is MODE, with bit 0 = channel 0 compare, bit 1 = channel 1 compare, bit 2 = output enable and bit 3 = output active level. Address 2 is EDGE, with bits 1:0 = trigger 0, bits 3:2 = trigger 1 and bits 5:4 = external clock. Addresses 3 and 4 hold the values of channels 0 and 1. Address 5 is the counter and is read-only. Every other address reads 0.

Top module: `tmr_dual_cc`

## Requirements
- R1: After reset all registers are 0 and the outputs are low. While run is 0, the counter, the prescaler, the output phase and the input filters are held cleared, so COUNT reads 0.
- R2: With run set, clock select n from 0 to 6 advances the counter once every 2^n system clocks. Select 7 advances it once per accepted external clock edge. The counter wraps from 0xFFFF to 0x0000.
- R3: An input level change is accepted only after it has been sampled unchanged on two consecutive clock edges. A pulse seen on one edge only is ignored.
- R4: The edge-select code is 0 for no edge, 1 for rising, 2 for falling and 3 for both.
- R5: In capture mode an accepted trigger edge copies the counter into the channel register and pulses the channel interrupt for one cycle. Both happen three clock edges after the edge at which the new level is first sampled.
- R6: If the capture event falls in the same cycle as a bus read of that channel's register, the interrupt still pulses but the register keeps its old value. If a bus write to the register falls in that cycle, the written value is stored.
- R7: In compare mode the channel interrupt pulses for one cycle on the count tick at which the counter equals the channel register.
- R8: When channel 0 is in compare mode, the tick at which it matches loads 0 into the counter instead of incrementing it.
- R9: When channel 1 is in compare mode and output enable is 1, each channel 1 match toggles the output phase. The pin is a register that is 0 when output enable is 0. Otherwise it equals the phase when active level is 1 and the inverted phase when active level is 0. It follows one edge after the phase or a MODE write.
- R10: While run is 1, writes to the clock-select field, to MODE and to EDGE are ignored. The run bit itself stays writable.
- R11: The register port returns read data one cycle after the read, using the map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after bus_rd |
| trig_in | input | 2 | External capture triggers, one per channel |
| ext_clk_in | input | 1 | External count clock |
| cc_irq | output | 2 | Channel interrupt pulses |
| tmr_out | output | 1 | Timer output pin |

## Verification
A capture event and a bus read of the same channel register can fall in the same cycle. The bench provokes this by toggling a trigger pin and then issuing the read at a range of offsets from zero to five cycles, so that exactly one offset lands on the capture cycle. Each case is judged against a cycle-accurate reference model. The model requires the interrupt pulse in every case and keeps the register value unchanged only for the colliding offset. Later reads of the register confirm that the value was kept.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EDG_NONE = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_sel_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_MODE  = 3'd1;
  localparam logic [2:0] A_EDGE  = 3'd2;
  localparam logic [2:0] A_CH0   = 3'd3;
  localparam logic [2:0] A_CH1   = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  localparam logic [2:0] SEL_EXT = 3'd7;
endpackage

// File: rtl/tmr_edge_filter.sv
module tmr_edge_filter
  import tmr_pkg::*;
#(
  parameter int STABLE = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      din,
  input  edge_sel_e sel,
  output logic      evt
);
  localparam int CW = $clog2(STABLE + 1);

  logic          smp;
  logic          acc;
  logic [CW-1:0] cnt;
  logic          wanted;

  always_comb begin
    wanted = (sel == EDG_BOTH) || (sel == EDG_RISE && smp) || (sel == EDG_FALL && !smp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp <= 1'b0;
      acc <= 1'b0;
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      smp <= din;
      evt <= 1'b0;
      if (!run) begin
        acc <= smp;
        cnt <= '0;
      end else if (smp == acc) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        acc <= smp;
        cnt <= '0;
        evt <= wanted;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R3: an accepted edge needs the new level on two consecutive samples
  a_r3_stable_two: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> ($past(smp, 1) == $past(smp, 2)));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int MAXLOG = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       ext_evt,
  output logic       tick
);
  localparam int PW = MAXLOG;

  logic [PW-1:0] pc;
  logic [PW:0]   lim_wide;
  logic          use_ext;

  always_comb begin
    use_ext  = (sel == tmr_pkg::SEL_EXT);
    lim_wide = ({{PW{1'b0}}, 1'b1} << sel) - {{PW{1'b0}}, 1'b1};
    tick     = run && (use_ext ? ext_evt : (pc == lim_wide[PW-1:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (!run || use_ext || tick) begin
      pc <= '0;
    end else begin
      pc <= pc + PW'(1);
    end
  end

  // R1: prescaler is held cleared while stopped
  a_r1_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cmp_mode,
  input  logic [W-1:0] count,
  input  logic         tick,
  input  logic         cap_evt,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ccr,
  output logic         match,
  output logic         irq
);
  logic do_cap;

  always_comb begin
    match  = run && cmp_mode && tick && (count == ccr);
    do_cap = run && !cmp_mode && cap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr <= '0;
      irq <= 1'b0;
    end else begin
      irq <= cmp_mode ? match : do_cap;
      if (wr_hit) begin
        ccr <= wdata;
      end else if (do_cap && !rd_hit) begin
        ccr <= count;
      end
    end
  end

  // R6: a capture colliding with a read leaves the register untouched
  a_r6_collide_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cap && rd_hit && !wr_hit) |=> $stable(ccr));

  // R5: a capture event raises the interrupt on the next cycle
  a_r5_cap_irq: assert property (@(posedge clk) disable iff (!rst_n)
    do_cap |=> irq);
endmodule

// File: rtl/tmr_dual_cc.sv
module tmr_dual_cc
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int STABLE = 2,
  parameter int MAXLOG = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [1:0]   trig_in,
  input  logic         ext_clk_in,
  output logic [1:0]   cc_irq,
  output logic         tmr_out
);
  localparam int NCH = 2;
  localparam int NIN = NCH + 1;

  logic            run;
  logic [2:0]      clksel;
  logic [NCH-1:0]  ch_cmp;
  logic            out_en;
  logic            out_lvl;
  edge_sel_e       esel [NIN];
  logic [W-1:0]    count;
  logic            phase;
  logic            tick;
  logic [NIN-1:0]  pin_in;
  logic [NIN-1:0]  pin_evt;
  logic [NCH-1:0]  match;
  logic [W-1:0]    ccr [NCH];

  assign pin_in = {ext_clk_in, trig_in};

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      clksel  <= '0;
      ch_cmp  <= '0;
      out_en  <= 1'b0;
      out_lvl <= 1'b0;
      for (int k = 0; k < NIN; k++) esel[k] <= EDG_NONE;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          run <= bus_wdata[0];
          if (!run) clksel <= bus_wdata[3:1];
        end
        A_MODE: if (!run) begin
          ch_cmp  <= bus_wdata[1:0];
          out_en  <= bus_wdata[2];
          out_lvl <= bus_wdata[3];
        end
        A_EDGE: if (!run) begin
          for (int k = 0; k < NIN; k++) esel[k] <= edge_sel_e'(bus_wdata[2*k +: 2]);
        end
        default: ;
      endcase
    end
  end

  // input qualification
  for (genvar k = 0; k < NIN; k++) begin : g_filt
    tmr_edge_filter #(.STABLE(STABLE)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .din  (pin_in[k]),
      .sel  (esel[k]),
      .evt  (pin_evt[k])
    );
  end

  tmr_prescaler #(.MAXLOG(MAXLOG)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sel    (clksel),
    .ext_evt(pin_evt[NIN-1]),
    .tick   (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .cmp_mode(ch_cmp[c]),
      .count   (count),
      .tick    (tick),
      .cap_evt (pin_evt[c]),
      .rd_hit  (bus_rd && bus_addr == (A_CH0 + 3'(c))),
      .wr_hit  (bus_wr && bus_addr == (A_CH0 + 3'(c))),
      .wdata   (bus_wdata),
      .ccr     (ccr[c]),
      .match   (match[c]),
      .irq     (cc_irq[c])
    );
  end

  // counter, output phase and pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      phase   <= 1'b0;
      tmr_out <= 1'b0;
    end else begin
      tmr_out <= out_en && (phase ^ ~out_lvl);
      if (!run) begin
        count <= '0;
        phase <= 1'b0;
      end else begin
        if (tick) count <= match[0] ? '0 : count + W'(1);
        if (match[1] && out_en) phase <= ~phase;
      end
    end
  end

  // register read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= W'({clksel, run});
        A_MODE:  bus_rdata <= W'({out_lvl, out_en, ch_cmp});
        A_EDGE:  bus_rdata <= W'({esel[2], esel[1], esel[0]});
        A_CH0:   bus_rdata <= ccr[0];
        A_CH1:   bus_rdata <= ccr[1];
        A_COUNT: bus_rdata <= count;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R1: counter held at zero while stopped
  a_r1_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  // R8: a channel 0 compare match restarts the period
  a_r8_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] |=> (count == '0));

  // R10: clock select frozen while running
  a_r10_clksel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(clksel));

  // R10: mode and output controls frozen while running
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ($stable(ch_cmp) && $stable(out_en) && $stable(out_lvl)));
endmodule

// File: tb/tmr_dual_cc_test.sv
module tmr_dual_cc_test;
  localparam int CLK_PERIOD = 10;
  localparam int STB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  trig_in = '0;
  logic        ext_clk_in = 1'b0;
  logic [15:0] bus_rdata;
  logic [1:0]  cc_irq;
  logic        tmr_out;

  tmr_dual_cc uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .ext_clk_in(ext_clk_in), .cc_irq(cc_irq), .tmr_out(tmr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int m_run, m_sel, m_oen, m_olv, m_cnt, m_ph, m_tout, m_rdata, m_pc;
  int m_cmp[2], m_ccr[2], m_irq[2];
  int m_es[3], m_smp[3], m_acc[3], m_st[3], m_evt[3];
  int t_tk, t_m0, t_m1, t_lim, t_din, t_ni0, t_ni1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_sel = 0; m_oen = 0; m_olv = 0; m_cnt = 0; m_ph = 0;
      m_tout = 0; m_rdata = 0; m_pc = 0;
      for (int i = 0; i < 2; i++) begin m_cmp[i] = 0; m_ccr[i] = 0; m_irq[i] = 0; end
      for (int k = 0; k < 3; k++) begin
        m_es[k] = 0; m_smp[k] = 0; m_acc[k] = 0; m_st[k] = 0; m_evt[k] = 0;
      end
    end else begin
      t_lim = (1 << m_sel) - 1;
      t_tk  = m_run && ((m_sel == 7) ? m_evt[2] : (m_pc == t_lim));
      t_m0  = m_run && m_cmp[0] && t_tk && (m_cnt == m_ccr[0]);
      t_m1  = m_run && m_cmp[1] && t_tk && (m_cnt == m_ccr[1]);
      t_ni0 = m_cmp[0] ? t_m0 : m_evt[0];
      t_ni1 = m_cmp[1] ? t_m1 : m_evt[1];
      if (bus_rd) begin
        case (bus_addr)
          0: m_rdata = m_sel * 2 + m_run;
          1: m_rdata = m_cmp[0] + 2 * m_cmp[1] + 4 * m_oen + 8 * m_olv;
          2: m_rdata = m_es[0] + 4 * m_es[1] + 16 * m_es[2];
          3: m_rdata = m_ccr[0];
          4: m_rdata = m_ccr[1];
          5: m_rdata = m_cnt;
          default: m_rdata = 0;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        if (bus_wr && bus_addr == 3 + i) m_ccr[i] = bus_wdata;
        else if (!m_cmp[i] && m_evt[i] && !(bus_rd && bus_addr == 3 + i)) m_ccr[i] = m_cnt;
      end
      m_tout = m_oen ? (m_ph ^ (m_olv ? 0 : 1)) : 0;
      if (!m_run) begin
        m_ph = 0; m_cnt = 0;
      end else begin
        if (t_m1 && m_oen) m_ph = m_ph ^ 1;
        if (t_tk) m_cnt = t_m0 ? 0 : ((m_cnt + 1) & 16'hFFFF);
      end
      if (!m_run || m_sel == 7) m_pc = 0;
      else m_pc = t_tk ? 0 : m_pc + 1;
      for (int k = 0; k < 3; k++) begin
        t_din = (k == 2) ? ext_clk_in : trig_in[k];
        m_evt[k] = 0;
        if (!m_run) begin
          m_acc[k] = m_smp[k]; m_st[k] = 0;
        end else if (m_smp[k] == m_acc[k]) begin
          m_st[k] = 0;
        end else if (m_st[k] == STB - 1) begin
          m_acc[k] = m_smp[k]; m_st[k] = 0;
          m_evt[k] = (m_es[k] == 3) || (m_es[k] == 1 && m_smp[k] == 1) || (m_es[k] == 2 && m_smp[k] == 0);
        end else begin
          m_st[k] = m_st[k] + 1;
        end
        m_smp[k] = t_din;
      end
      m_irq[0] = t_ni0;
      m_irq[1] = t_ni1;
      if (bus_wr) begin
        case (bus_addr)
          0: begin
            if (!m_run) m_sel = (bus_wdata >> 1) & 7;
            m_run = bus_wdata & 1;
          end
          1: if (!m_run) begin
            m_cmp[0] = bus_wdata[0]; m_cmp[1] = bus_wdata[1];
            m_oen = bus_wdata[2]; m_olv = bus_wdata[3];
          end
          2: if (!m_run) begin
            m_es[0] = bus_wdata[1:0]; m_es[1] = bus_wdata[3:2]; m_es[2] = bus_wdata[5:4];
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "cc_irq[0] (R5 R7)", cc_irq[0], m_irq[0]);
      chk(cur_req, "cc_irq[1] (R5 R7)", cc_irq[1], m_irq[1]);
      chk(cur_req, "tmr_out (R9)", tmr_out, m_tout);
      chk(cur_req, "bus_rdata (R11)", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset irq", cc_irq, 0);
    chk("R1", "reset tmr_out", tmr_out, 0);
    chk("R1", "reset rdata", bus_rdata, 0);
    rst_n = 1'b1;
    idle(5);
    rd(5);
    chk("R1", "stopped count", bus_rdata, 0);

    // R2: each prescaler division
    cur_req = "R2";
    for (int s = 0; s < 7; s++) begin
      wr(0, 0);
      wr(0, s * 2);
      wr(0, s * 2 + 1);
      idle(130 + 7 * s);
      rd(5);
      rd(0);
    end
    wr(0, 0);
    rd(5);
    chk("R1", "count after stop", bus_rdata, 0);

    // R2: wrap at divide-by-one
    wr(0, 1);
    idle(65540);
    rd(5);
    wr(0, 0);

    // R3 and R4: external clock with pulses of 1, 2 and 3 cycles
    cur_req = "R3";
    for (int e = 0; e < 4; e++) begin
      wr(0, 0);
      wr(2, e << 4);
      wr(0, 15);
      for (int w = 1; w <= 3; w++) begin
        @(negedge clk); ext_clk_in = 1'b1;
        idle(w);
        ext_clk_in = 1'b0;
        idle(6);
      end
      rd(5);
    end
    wr(0, 0);

    // R4 and R5: capture edges on both triggers
    cur_req = "R5";
    wr(1, 0);
    for (int e = 0; e < 4; e++) begin
      wr(0, 0);
      wr(2, e | ((3 - e) << 2));
      wr(0, 1);
      for (int p = 0; p < 4; p++) begin
        idle(7 + p);
        trig_in = ~trig_in;
        idle(8);
        rd(3);
        rd(4);
      end
    end
    wr(0, 0);
    trig_in = '0;

    // R6: collision sweep between capture and read of channel 0
    cur_req = "R6";
    wr(2, 3);
    wr(0, 1);
    for (int off = 0; off < 6; off++) begin
      idle(5);
      trig_in[0] = ~trig_in[0];
      idle(off);
      rd(3);
      idle(6);
      rd(3);
    end
    // capture with a simultaneous write: the write value wins
    idle(4);
    trig_in[0] = ~trig_in[0];
    idle(2);
    wr(3, 16'h1234);
    idle(3);
    rd(3);
    chk("R6", "write beats capture", bus_rdata, 16'h1234);
    wr(0, 0);

    // R7 and R8: channel 0 sets the period
    cur_req = "R8";
    wr(1, 1);
    wr(3, 9);
    wr(0, 1);
    idle(47);
    rd(5);
    wr(0, 0);
    wr(0, 2 * 2);
    wr(0, 2 * 2 + 1);
    idle(90);
    rd(5);
    wr(0, 0);

    // R9: channel 1 toggles the output, both levels
    cur_req = "R9";
    wr(3, 20);
    wr(4, 5);
    wr(1, 4'b0111);
    wr(0, 1);
    idle(80);
    wr(0, 0);
    wr(1, 4'b1111);
    wr(0, 1);
    idle(80);
    wr(0, 0);
    wr(1, 4'b1010);
    idle(4);
    chk("R9", "disabled output", tmr_out, 0);

    // R10: frozen configuration while running
    cur_req = "R10";
    wr(1, 4'b0110);
    wr(2, 6'h05);
    wr(0, 3 * 2 + 1);
    wr(0, 5 * 2 + 1);
    wr(1, 4'b1001);
    wr(2, 6'h3A);
    rd(0);
    chk("R10", "CTRL while running", bus_rdata, 3 * 2 + 1);
    rd(1);
    chk("R10", "MODE while running", bus_rdata, 4'b0110);
    rd(2);
    chk("R10", "EDGE while running", bus_rdata, 6'h05);
    wr(0, 0);

    cur_req = "R11";
    rd(6);
    chk("R11", "unmapped address", bus_rdata, 0);
    rd(0);
    chk("R11", "CTRL after stop", bus_rdata, 3 * 2);
    idle(3);
    summary();
  end
endmodule